// File: doc/BRIEF.md
# Halt and Stop Power-Mode Controller

This block steers a small processor subsystem between three operating modes. In run mode the CPU executes and the peripherals are clocked. A halt request stops instruction execution, but the peripherals stay clocked and their control registers keep their programmed settings. A clock-stop request first sends a one-cycle synchronous reset to the peripheral control registers and then gates the peripheral clock off.

Each request carries a 4-bit condition operand, which is latched into a status register. For halt, the operand selects the events that may end the halt. Bit 3 enables release by an accepted interrupt, and bit 2 enables release by a timer tick. Bits 1:0 carry no meaning. Clock stop ends when any enabled interrupt is pending. A programmable oscillator-settling count then runs before the CPU starts again. A status code reports the current mode, and a wake-source code records which event caused the last exit.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset, mode is 2'b00 (run), cpu_en and periph_clk_en are 1, ctrl_rst is 0, wake_src is 2'b00 and rel_cond is 0. In run mode both enables are 1, and mode never reads 2'b11.
- R2: In run, a halt_req whose halt_cond has bit 3 or bit 2 set moves the block to halt on the next cycle. In halt, mode is 2'b01, cpu_en is 0, periph_clk_en stays 1, ctrl_rst stays 0, and rel_cond holds halt_cond.
- R3: A halt_req whose halt_cond has bits 3:2 both 0 is a no-op, and the block stays in run with cpu_en 1.
- R4: In halt with halt_cond bit 3 set, gie 1 and irq_pend & irq_en nonzero, irq_take is a one-hot mark of the lowest-index eligible line in that same cycle. On the next cycle the block is in run with wake_src 2'b01. A pending request that is masked, or arrives while gie is 0, does not end the halt, and irq_take stays 0.
- R5: In halt with halt_cond bit 2 set, tmr_tick returns the block to run on the next cycle with wake_src 2'b10. If the interrupt release is also eligible in that cycle, wake_src is 2'b01. Without bit 3, interrupts do not release the halt.
- R6: In run, stop_req with any stop_cond (0000 included) gives one cycle with mode 2'b10, ctrl_rst 1, periph_clk_en 1 and cpu_en 0. From the following cycle ctrl_rst is 0 and periph_clk_en is 0. rel_cond holds stop_cond.
- R7: In clock stop, irq_pend & irq_en nonzero (gie ignored) starts a wait of settle_len+1 cycles with cpu_en and periph_clk_en still 0. The block then returns to run with wake_src 2'b11. tmr_tick has no effect in clock stop.
- R8: When stop_req and a valid halt_req arrive in the same run cycle, clock stop is entered.
- R9: halt_req and stop_req are ignored outside run mode. Mode, ctrl_rst and rel_cond do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Decoded halt request |
| halt_cond | input | 4 | Halt release-condition operand |
| stop_req | input | 1 | Decoded clock-stop request |
| stop_cond | input | 4 | Clock-stop operand |
| irq_pend | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| gie | input | 1 | Global interrupt enable |
| tmr_tick | input | 1 | Timer event for halt release |
| settle_len | input | SETTLE_W | Oscillator-settling wait length |
| cpu_en | output | 1 | CPU execution enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| ctrl_rst | output | 1 | Peripheral control-register reset pulse |
| irq_take | output | NUM_IRQ | One-hot interrupt accepted on halt release |
| mode | output | 2 | Current mode: 00 run, 01 halt, 10 stop |
| wake_src | output | 2 | Last exit cause: 01 halt-irq, 10 halt-timer, 11 stop-irq |
| rel_cond | output | 4 | Latched condition operand |

## Verification
Two pairs of events can fall in the same cycle. In halt with both release bits set, an accepted interrupt and a timer tick can arrive together, and the interrupt must win the wake-source code. In run, a clock-stop request and a valid halt request can arrive together, and clock stop must win. The bench raises the tick at random during interrupt releases. On a share of clock-stop entries it also asserts a halt request at the same time. It then checks the next cycle's mode, wake_src, ctrl_rst and rel_cond against values it computes itself.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

  localparam int COND_W       = 4;
  localparam int COND_IRQ_BIT = 3;
  localparam int COND_TMR_BIT = 2;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_HALT,
    ST_STOP_ENT,
    ST_STOP,
    ST_SETTLE
  } pm_state_e;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_HALT = 2'b01;
  localparam logic [1:0] MODE_STOP = 2'b10;

  localparam logic [1:0] WSRC_NONE     = 2'b00;
  localparam logic [1:0] WSRC_HALT_IRQ = 2'b01;
  localparam logic [1:0] WSRC_HALT_TMR = 2'b10;
  localparam logic [1:0] WSRC_STOP_IRQ = 2'b11;

  // A halt operand is usable only when it names at least one release source.
  function automatic logic halt_cond_valid(input logic [COND_W-1:0] c);
    return c[COND_IRQ_BIT] | c[COND_TMR_BIT];
  endfunction

  // Map internal state to the external mode code.
  function automatic logic [1:0] mode_of(input pm_state_e s);
    case (s)
      ST_RUN:  return MODE_RUN;
      ST_HALT: return MODE_HALT;
      default: return MODE_STOP;
    endcase
  endfunction

endpackage

// File: rtl/pwrmode_wake.sv
module pwrmode_wake #(
  parameter int NUM_IRQ = 4
) (
  input  logic               in_halt,
  input  logic               in_stop,
  input  logic               use_irq,
  input  logic               use_tmr,
  input  logic               gie,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               tmr_tick,
  output logic               halt_wake,
  output logic               halt_by_irq,
  output logic               stop_wake,
  output logic [NUM_IRQ-1:0] irq_take
);

  logic [NUM_IRQ-1:0] elig;
  logic [NUM_IRQ-1:0] first;
  logic [NUM_IRQ:0]   seen;
  logic               any_elig;
  logic               halt_by_tmr;

  assign elig    = irq_pend & irq_en;
  assign seen[0] = 1'b0;

  // Priority chain: the lowest index that is eligible gets the mark.
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    assign first[g]  = elig[g] & ~seen[g];
    assign seen[g+1] = seen[g] | elig[g];
  end

  assign any_elig    = seen[NUM_IRQ];
  assign halt_by_irq = in_halt & use_irq & gie & any_elig;
  assign halt_by_tmr = in_halt & use_tmr & tmr_tick;
  assign halt_wake   = halt_by_irq | halt_by_tmr;
  assign stop_wake   = in_stop & any_elig;
  assign irq_take    = halt_by_irq ? first : '0;

endmodule

// File: rtl/pwrmode_settle.sv
module pwrmode_settle #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         active,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= load_val;
    else if (active && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = active && (cnt_q == '0);

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic [3:0]          halt_cond,
  input  logic                stop_req,
  input  logic [3:0]          stop_cond,
  input  logic [NUM_IRQ-1:0]  irq_pend,
  input  logic [NUM_IRQ-1:0]  irq_en,
  input  logic                gie,
  input  logic                tmr_tick,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic                cpu_en,
  output logic                periph_clk_en,
  output logic                ctrl_rst,
  output logic [NUM_IRQ-1:0]  irq_take,
  output logic [1:0]          mode,
  output logic [1:0]          wake_src,
  output logic [3:0]          rel_cond
);

  pm_state_e         state_q, state_d;
  logic [COND_W-1:0] rel_cond_q;
  logic [1:0]        wake_src_q;

  // Named internal events, visible to the bound checker.
  logic in_run, in_halt, in_stop, in_settle;
  logic halt_ok, enter_halt, enter_stop, halt_noop;
  logic halt_wake, halt_by_irq, stop_wake, settle_done;

  assign in_run    = (state_q == ST_RUN);
  assign in_halt   = (state_q == ST_HALT);
  assign in_stop   = (state_q == ST_STOP);
  assign in_settle = (state_q == ST_SETTLE);

  assign halt_ok    = halt_cond_valid(halt_cond);
  assign enter_stop = in_run & stop_req;
  assign enter_halt = in_run & halt_req & ~stop_req & halt_ok;
  assign halt_noop  = in_run & halt_req & ~stop_req & ~halt_ok;

  pwrmode_wake #(.NUM_IRQ(NUM_IRQ)) wake_i (
    .in_halt     (in_halt),
    .in_stop     (in_stop),
    .use_irq     (rel_cond_q[COND_IRQ_BIT]),
    .use_tmr     (rel_cond_q[COND_TMR_BIT]),
    .gie         (gie),
    .irq_pend    (irq_pend),
    .irq_en      (irq_en),
    .tmr_tick    (tmr_tick),
    .halt_wake   (halt_wake),
    .halt_by_irq (halt_by_irq),
    .stop_wake   (stop_wake),
    .irq_take    (irq_take)
  );

  pwrmode_settle #(.W(SETTLE_W)) settle_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stop_wake),
    .load_val (settle_len),
    .active   (in_settle),
    .done     (settle_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (enter_stop)      state_d = ST_STOP_ENT;
        else if (enter_halt) state_d = ST_HALT;
      end
      ST_HALT:     if (halt_wake)   state_d = ST_RUN;
      ST_STOP_ENT:                  state_d = ST_STOP;
      ST_STOP:     if (stop_wake)   state_d = ST_SETTLE;
      ST_SETTLE:   if (settle_done) state_d = ST_RUN;
      default:                      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rel_cond_q <= '0;
    else if (enter_stop) rel_cond_q <= stop_cond;
    else if (enter_halt) rel_cond_q <= halt_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wake_src_q <= WSRC_NONE;
    else if (halt_wake) wake_src_q <= halt_by_irq ? WSRC_HALT_IRQ : WSRC_HALT_TMR;
    else if (stop_wake) wake_src_q <= WSRC_STOP_IRQ;
  end

  assign cpu_en        = in_run;
  assign periph_clk_en = in_run | in_halt | (state_q == ST_STOP_ENT);
  assign ctrl_rst      = (state_q == ST_STOP_ENT);
  assign mode          = mode_of(state_q);
  assign wake_src      = wake_src_q;
  assign rel_cond      = rel_cond_q;

endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk
  import pwrmode_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gie,
  input logic               cpu_en,
  input logic               periph_clk_en,
  input logic               ctrl_rst,
  input logic [NUM_IRQ-1:0] irq_take,
  input logic [1:0]         mode,
  input logic [1:0]         wake_src,
  input logic               enter_stop,
  input logic               halt_noop,
  input logic               stop_wake
);

  a_r1_run_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN) |-> (cpu_en && periph_clk_en));

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  a_r2_halt_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALT) |-> (periph_clk_en && !cpu_en && !ctrl_rst));

  a_r3_noop_stays: assert property (@(posedge clk) disable iff (!rst_n)
    halt_noop |=> (mode == MODE_RUN && cpu_en));

  a_r4_take_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_take));

  a_r4_take_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_take) |-> gie);

  a_r4_take_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_take) |=> (mode == MODE_RUN && wake_src == WSRC_HALT_IRQ));

  a_r6_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    enter_stop |=> (ctrl_rst && periph_clk_en && mode == MODE_STOP));

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> !ctrl_rst);

  a_r6_clock_off_after: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> !periph_clk_en);

  a_r7_stop_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP) |-> !cpu_en);

  a_r7_wake_waits: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wake |=> (!cpu_en && !periph_clk_en));

endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .gie           (gie),
  .cpu_en        (cpu_en),
  .periph_clk_en (periph_clk_en),
  .ctrl_rst      (ctrl_rst),
  .irq_take      (irq_take),
  .mode          (mode),
  .wake_src      (wake_src),
  .enter_stop    (enter_stop),
  .halt_noop     (halt_noop),
  .stop_wake     (stop_wake)
);

// File: tb/pwrmode_ctrl_tb_top.sv
module pwrmode_ctrl_tb_top;
  localparam int NI = 4;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          halt_req, stop_req, gie, tmr_tick;
  logic [3:0]    halt_cond, stop_cond;
  logic [NI-1:0] irq_pend, irq_en;
  logic [SW-1:0] settle_len;
  logic          cpu_en, periph_clk_en, ctrl_rst;
  logic [NI-1:0] irq_take;
  logic [1:0]    mode, wake_src;
  logic [3:0]    rel_cond;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwrmode_ctrl #(.NUM_IRQ(NI), .SETTLE_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_cond(halt_cond),
    .stop_req(stop_req), .stop_cond(stop_cond), .irq_pend(irq_pend),
    .irq_en(irq_en), .gie(gie), .tmr_tick(tmr_tick), .settle_len(settle_len),
    .cpu_en(cpu_en), .periph_clk_en(periph_clk_en), .ctrl_rst(ctrl_rst),
    .irq_take(irq_take), .mode(mode), .wake_src(wake_src), .rel_cond(rel_cond)
  );

  function automatic logic [NI-1:0] exp_first(input logic [NI-1:0] v);
    for (int i = 0; i < NI; i++) if (v[i]) return NI'(1) << i;
    return '0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic quiet();
    halt_req = 0; stop_req = 0; tmr_tick = 0; gie = 0;
    irq_pend = '0; irq_en = '0; halt_cond = '0; stop_cond = '0;
  endtask

  task automatic enter_halt(input logic [3:0] c);
    halt_req = 1; halt_cond = c;
    cyc();
    halt_req = 0;
    check("R2", "mode", mode, 2'b01);
    check("R2", "cpu_en", cpu_en, 0);
    check("R2", "pclk", periph_clk_en, 1);
    check("R2", "rel_cond", rel_cond, c);
  endtask

  task automatic wake_pair(output logic [NI-1:0] p, output logic [NI-1:0] e);
    int b = $urandom % NI;
    p = NI'($urandom) | (NI'(1) << b);
    e = NI'($urandom) | (NI'(1) << b);
  endtask

  initial begin
    logic [NI-1:0] p, e;
    logic [3:0] c;
    void'($urandom(32'h5eed1706));
    quiet();
    settle_len = '0;
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    check("R1", "mode", mode, 2'b00);
    check("R1", "cpu_en", cpu_en, 1);
    check("R1", "pclk", periph_clk_en, 1);
    check("R1", "ctrl_rst", ctrl_rst, 0);
    check("R1", "wake_src", wake_src, 0);
    check("R1", "rel_cond", rel_cond, 0);

    // R3 halt with no release source
    for (int i = 0; i < 6; i++) begin
      halt_req = 1; halt_cond = 4'($urandom & 3);
      cyc();
      halt_req = 0;
      check("R3", "mode", mode, 2'b00);
      check("R3", "cpu_en", cpu_en, 1);
    end

    // R4 halt released by an accepted interrupt
    for (int i = 0; i < 25; i++) begin
      c = 4'b1000 | 4'($urandom & 4'b0111);
      enter_halt(c);
      for (int k = 0; k < int'($urandom % 4); k++) begin
        irq_pend = NI'($urandom);
        if ($urandom % 2) begin irq_en = ~irq_pend; gie = 1; end
        else begin irq_en = NI'($urandom); gie = 0; end
        halt_req = $urandom % 2; stop_req = $urandom % 2;
        halt_cond = 4'b1100;
        #1;
        check("R4", "no take", irq_take, 0);
        cyc();
        check("R9", "mode held", mode, 2'b01);
        check("R9", "ctrl_rst", ctrl_rst, 0);
        check("R9", "rel_cond", rel_cond, c);
      end
      halt_req = 0; stop_req = 0;
      wake_pair(p, e);
      irq_pend = p; irq_en = e; gie = 1;
      tmr_tick = c[2] ? 1'($urandom) : 1'b0;
      #1;
      check("R4", "irq_take", irq_take, exp_first(p & e));
      cyc();
      check("R4", "mode", mode, 2'b00);
      check("R4", "cpu_en", cpu_en, 1);
      check(tmr_tick ? "R5" : "R4", "wake_src", wake_src, 2'b01);
      quiet();
    end

    // R5 halt released by the timer tick
    for (int i = 0; i < 15; i++) begin
      c = 4'b0100 | 4'($urandom & 4'b1011);
      enter_halt(c);
      for (int k = 0; k < int'($urandom % 4) + 1; k++) begin
        if (!c[3]) begin wake_pair(p, e); irq_pend = p; irq_en = e; gie = 1; end
        #1;
        check("R5", "no take", irq_take, 0);
        cyc();
        check("R5", "mode held", mode, 2'b01);
      end
      tmr_tick = 1;
      #1;
      check("R5", "tick take", irq_take, 0);
      cyc();
      check("R5", "mode", mode, 2'b00);
      check("R5", "wake_src", wake_src, 2'b10);
      quiet();
    end

    // R6/R7/R8 clock stop entry, hold and settled release
    for (int i = 0; i < 15; i++) begin
      int n;
      c = (i == 0) ? 4'b0000 : 4'($urandom);
      stop_req = 1; stop_cond = c;
      if (i % 3 == 0) begin halt_req = 1; halt_cond = 4'b1000; end
      cyc();
      quiet();
      check((i % 3 == 0) ? "R8" : "R6", "mode", mode, 2'b10);
      check("R6", "ctrl_rst", ctrl_rst, 1);
      check("R6", "pclk", periph_clk_en, 1);
      check("R6", "cpu_en", cpu_en, 0);
      check("R6", "rel_cond", rel_cond, c);
      cyc();
      check("R6", "ctrl_rst off", ctrl_rst, 0);
      check("R6", "pclk off", periph_clk_en, 0);
      for (int k = 0; k < int'($urandom % 4); k++) begin
        tmr_tick = $urandom % 2; halt_req = $urandom % 2; stop_req = $urandom % 2;
        halt_cond = 4'b1100; stop_cond = ~c;
        irq_pend = NI'($urandom); irq_en = ~irq_pend; gie = $urandom % 2;
        cyc();
        check("R9", "stop held", mode, 2'b10);
        check("R7", "pclk", periph_clk_en, 0);
        check("R9", "ctrl_rst", ctrl_rst, 0);
        check("R9", "rel_cond", rel_cond, c);
      end
      quiet();
      n = (i == 1) ? 0 : int'($urandom % 13);
      settle_len = SW'(n);
      wake_pair(p, e);
      irq_pend = p; irq_en = e; gie = 0;
      cyc();
      quiet();
      check("R7", "settle cpu", cpu_en, 0);
      for (int k = 0; k < n; k++) begin
        cyc();
        check("R7", "settle cpu", cpu_en, 0);
        check("R7", "settle pclk", periph_clk_en, 0);
      end
      cyc();
      check("R7", "cpu_en", cpu_en, 1);
      check("R7", "mode", mode, 2'b00);
      check("R7", "wake_src", wake_src, 2'b11);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule